// File: doc/BRIEF.md
# DRAM Size-Probe Row Alias Decoder

This block makes a memory system look like a DRAM array wired with fewer row address lines than the controller was told about. Boot firmware sizes memory by setting up the widest row addressing, writing a marker at a row boundary and reading it back from the start of memory. If the two locations turn out to be the same, the firmware knows how many row bits are really present. The block gives that wrap-around behaviour to a flat memory. It places a 4 KiB alias window at the address where a wrapped array would fold back, and it sends any request that falls inside that window to the first 4 KiB of the memory base.

A single 32-bit geometry register sits at register offset 0. It holds the row-bit field, the bank-bit field and the page-size field. The installed memory size, in MiB, is a static input. Each write to the geometry register decides, in the same clock edge, whether the window is switched off, moved and switched on, or left as it is. Request translation is combinational from the registered window state.

Top module: `dram_probe_alias`

## Requirements
- R1: After reset the geometry register reads 0 and the window is off. The window start reads MEM_BASE + 1 MiB, and every request address passes through unchanged with alias_hit low.
- R2: A write with reg_wr_en high and reg_addr equal to 0 stores reg_wdata into the geometry register, and reg_rdata returns that value when reg_addr is 0. A write to any other offset changes neither the register nor the window, and reads at any other offset return 0.
- R3: The geometry word is decoded as follows. The configured row count is bits [7:4] plus 1. The bank-bit count is bit 2 plus 2. The page size in bytes is 2 to the power of (bits [11:8] plus 3).
- R4: The installed sizes 256, 512, 1024 and 2048 MiB have an actual row count of log2(size) + 3. When the configured row count equals that count, a geometry write switches the window off and leaves its start unchanged.
- R5: For installed sizes of 256, 512 and 1024 MiB, a geometry write with a mismatching row count switches the window on. The window start becomes MEM_BASE + 2^(actual rows + bank bits) × page size.
- R6: With 2048 MiB installed, a geometry write with a mismatching row count leaves both the window enable and the window start unchanged.
- R7: size_err is high exactly when size_mib is not one of 256, 512, 1024 or 2048. With such a size, no geometry write changes the window.
- R8: While the window is on, a request address A with win_start <= A < win_start + 4096 gives xlat_addr = MEM_BASE + (A - win_start), with alias_hit high.
- R9: Every other request address, including win_start - 4 and win_start + 4096, passes through unchanged with alias_hit low.
- R10: A geometry write takes effect at the clock edge that captures it. During the write cycle the old window is still in use, and from the next cycle on the new one applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ROFF_W | Register byte offset, used for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| size_mib | input | SIZE_W | Installed memory size in MiB (static) |
| size_err | output | 1 | Installed size is not a supported value |
| req_addr | input | AW | Incoming memory request address |
| xlat_addr | output | AW | Translated memory address |
| alias_hit | output | 1 | The request fell inside the alias window |
| alias_en | output | 1 | The alias window is switched on |
| win_start | output | AW | Current alias window start address |

## Verification
The bench builds the block with its defaults: a 36-bit address and a memory base of 0x4000_0000. With that width, the largest window offset (2^34) plus the base still fits without wrapping, so each legal geometry places a distinct window. Because the base is nonzero, a translated address base + offset cannot be mistaken for a pass-through of the bare offset. The bench resets the block with each supported size and with an unsupported one, so the enable, disable, unchanged and error paths are all reached.

// File: rtl/dram_probe_pkg.sv
// Package: shared field positions and the window-update action type.
// Assumes a 32-bit geometry word; only the listed fields are decoded.
package dram_probe_pkg;

    localparam int ROWS_LSB  = 4;   // configured rows - 1, four bits
    localparam int BANK_BIT  = 2;   // bank bits - 2
    localparam int PAGE_LSB  = 8;   // log2(page bytes) - 3, four bits
    localparam int FIELD4_W  = 4;

    typedef enum logic [1:0] {
        WIN_KEEP    = 2'd0,
        WIN_DISABLE = 2'd1,
        WIN_ENABLE  = 2'd2
    } win_act_e;

endpackage

// File: rtl/dram_probe_geom.sv
// Module: combinational decoder from geometry word and installed size to a
// window action and candidate window start. Assumes sizes are powers of two
// listed from 2^MIN_LG MiB upward; only the first PROBE_SIZES of them have a
// usable actual row count.
module dram_probe_geom
    import dram_probe_pkg::*;
#(
    parameter int           AW          = 36,
    parameter int           SIZE_W      = 12,
    parameter logic [AW-1:0] MEM_BASE   = 36'h0_4000_0000,
    parameter int           MIN_LG      = 8,
    parameter int           NUM_SIZES   = 4,
    parameter int           PROBE_SIZES = 3,
    parameter int           ROW_OFFSET  = 3
) (
    input  logic [31:0]       geom_word,
    input  logic [SIZE_W-1:0] size_mib,
    output win_act_e          action,
    output logic [AW-1:0]     new_start,
    output logic              size_err
);
    localparam int LG_W    = 5;
    localparam int SHIFT_W = 7;

    logic [LG_W-1:0]    size_lg;
    logic               size_ok;
    logic               probe_ok;
    logic [LG_W-1:0]    cfg_rows;
    logic [LG_W-1:0]    act_rows;
    logic [1:0]         bank_bits;
    logic [LG_W-1:0]    page_lg;
    logic [SHIFT_W-1:0] shift_amt;

    // Find the installed size among the supported powers of two.
    always_comb begin
        size_lg  = '0;
        size_ok  = 1'b0;
        probe_ok = 1'b0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (size_mib == SIZE_W'(1 << (MIN_LG + i))) begin
                size_ok  = 1'b1;
                size_lg  = LG_W'(MIN_LG + i);
                probe_ok = (i < PROBE_SIZES);
            end
        end
    end

    // Decode the geometry fields and form the window offset exponent.
    always_comb begin
        cfg_rows  = LG_W'(geom_word[ROWS_LSB +: FIELD4_W]) + LG_W'(1);
        bank_bits = 2'd2 + {1'b0, geom_word[BANK_BIT]};
        page_lg   = LG_W'(geom_word[PAGE_LSB +: FIELD4_W]) + LG_W'(3);
        act_rows  = size_lg + LG_W'(ROW_OFFSET);
        shift_amt = SHIFT_W'(act_rows) + SHIFT_W'(bank_bits) + SHIFT_W'(page_lg);
        new_start = MEM_BASE + (AW'(1) << shift_amt);
    end

    // Choose what a geometry write does to the window.
    always_comb begin
        if (size_ok && (cfg_rows == act_rows))
            action = WIN_DISABLE;
        else if (probe_ok)
            action = WIN_ENABLE;
        else
            action = WIN_KEEP;
    end

    assign size_err = !size_ok;

endmodule

// File: rtl/dram_probe_window.sv
// Module: holds the geometry register and the alias window state.
// Assumes a synchronous active-low reset; updates only on geometry writes.
module dram_probe_window
    import dram_probe_pkg::*;
#(
    parameter int            AW        = 36,
    parameter logic [AW-1:0] RST_START = 36'h0_4010_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          geom_wr,
    input  logic [31:0]   geom_word,
    input  win_act_e      action,
    input  logic [AW-1:0] new_start,
    output logic [31:0]   ctrl_q,
    output logic          win_en,
    output logic [AW-1:0] win_base
);
    // Capture the geometry word and apply the decoded window action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            win_en   <= 1'b0;
            win_base <= RST_START;
        end else if (geom_wr) begin
            ctrl_q <= geom_word;
            case (action)
                WIN_DISABLE: win_en <= 1'b0;
                WIN_ENABLE: begin
                    win_en   <= 1'b1;
                    win_base <= new_start;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dram_probe_xlat.sv
// Module: combinational request translation through the alias window.
// Assumes the window start plus WIN_BYTES does not exceed the address space.
module dram_probe_xlat #(
    parameter int            AW        = 36,
    parameter logic [AW-1:0] MEM_BASE  = 36'h0_4000_0000,
    parameter int            WIN_BYTES = 4096
) (
    input  logic          win_en,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] req_addr,
    output logic [AW-1:0] xlat_addr,
    output logic          hit
);
    logic [AW-1:0] delta;

    // Redirect hits to the base of memory; pass all else through.
    always_comb begin
        delta     = req_addr - win_base;
        hit       = win_en && (req_addr >= win_base) && (delta < AW'(WIN_BYTES));
        xlat_addr = hit ? (MEM_BASE + delta) : req_addr;
    end

endmodule

// File: rtl/dram_probe_alias.sv
// Module: top of the size-probe row alias decoder. One geometry register at
// offset CTRL_OFF; all other offsets read zero and ignore writes.
// Assumes size_mib is held stable outside reset.
module dram_probe_alias
    import dram_probe_pkg::*;
#(
    parameter int            AW        = 36,
    parameter int            ROFF_W    = 12,
    parameter int            SIZE_W    = 12,
    parameter logic [AW-1:0] MEM_BASE  = 36'h0_4000_0000,
    parameter int            WIN_BYTES = 4096,
    parameter int            RST_OFF   = 1048576
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ROFF_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [SIZE_W-1:0] size_mib,
    output logic              size_err,
    input  logic [AW-1:0]     req_addr,
    output logic [AW-1:0]     xlat_addr,
    output logic              alias_hit,
    output logic              alias_en,
    output logic [AW-1:0]     win_start
);
    localparam logic [ROFF_W-1:0] CTRL_OFF  = '0;
    localparam logic [AW-1:0]     RST_START = MEM_BASE + AW'(RST_OFF);

    win_act_e      action;
    logic [AW-1:0] new_start;
    logic [31:0]   ctrl_q;
    logic          geom_wr;

    assign geom_wr = reg_wr_en && (reg_addr == CTRL_OFF);

    dram_probe_geom #(
        .AW(AW), .SIZE_W(SIZE_W), .MEM_BASE(MEM_BASE)
    ) geom_i (
        .geom_word(reg_wdata), .size_mib(size_mib),
        .action(action), .new_start(new_start), .size_err(size_err)
    );

    dram_probe_window #(
        .AW(AW), .RST_START(RST_START)
    ) win_i (
        .clk(clk), .rst_n(rst_n), .geom_wr(geom_wr), .geom_word(reg_wdata),
        .action(action), .new_start(new_start),
        .ctrl_q(ctrl_q), .win_en(alias_en), .win_base(win_start)
    );

    dram_probe_xlat #(
        .AW(AW), .MEM_BASE(MEM_BASE), .WIN_BYTES(WIN_BYTES)
    ) xlat_i (
        .win_en(alias_en), .win_base(win_start), .req_addr(req_addr),
        .xlat_addr(xlat_addr), .hit(alias_hit)
    );

    // Register readback: only the geometry register is implemented.
    always_comb begin
        reg_rdata = (reg_addr == CTRL_OFF) ? ctrl_q : 32'd0;
    end

endmodule

// File: rtl/dram_probe_alias_chk.sv
// Module: property checker for dram_probe_alias, attached with bind.
module dram_probe_alias_chk #(
    parameter int            AW        = 36,
    parameter int            ROFF_W    = 12,
    parameter int            SIZE_W    = 12,
    parameter logic [AW-1:0] MEM_BASE  = 36'h0_4000_0000,
    parameter int            WIN_BYTES = 4096
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ROFF_W-1:0] reg_addr,
    input logic [SIZE_W-1:0] size_mib,
    input logic              size_err,
    input logic [AW-1:0]     req_addr,
    input logic [AW-1:0]     xlat_addr,
    input logic              alias_hit,
    input logic              alias_en,
    input logic [AW-1:0]     win_start,
    input logic [31:0]       ctrl_q
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!alias_en && ctrl_q == 32'd0));

    assert_other_offset_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr != '0) |=> $stable(ctrl_q));

    assert_window_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_addr == '0) |=> ($stable(alias_en) && $stable(win_start)));

    assert_largest_size_never_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (size_mib == SIZE_W'(2048)) |-> !alias_en);

    assert_bad_size_never_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        size_err |-> !alias_en);

    assert_hit_lands_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alias_hit |-> (alias_en && req_addr >= win_start && xlat_addr >= MEM_BASE
                       && (xlat_addr - MEM_BASE) < AW'(WIN_BYTES)));

    assert_miss_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !alias_hit |-> (xlat_addr == req_addr));

endmodule

bind dram_probe_alias dram_probe_alias_chk #(
    .AW(AW), .ROFF_W(ROFF_W), .SIZE_W(SIZE_W), .MEM_BASE(MEM_BASE), .WIN_BYTES(WIN_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .size_mib(size_mib), .size_err(size_err), .req_addr(req_addr),
    .xlat_addr(xlat_addr), .alias_hit(alias_hit), .alias_en(alias_en),
    .win_start(win_start), .ctrl_q(ctrl_q)
);

// File: tb/dram_probe_alias_tb.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops and
// compares them at the falling clock edge.
module dram_probe_alias_tb_top;
    localparam int            CLK_PERIOD = 10;
    localparam int            AW         = 36;
    localparam logic [AW-1:0] BASE       = 36'h0_4000_0000;
    localparam longint        AMASK      = (64'd1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [11:0]   size_mib = 12'd256;
    logic          size_err;
    logic [AW-1:0] req_addr = '0;
    logic [AW-1:0] xlat_addr;
    logic          alias_hit;
    logic          alias_en;
    logic [AW-1:0] win_start;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_probe_alias dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .size_mib(size_mib),
        .size_err(size_err), .req_addr(req_addr), .xlat_addr(xlat_addr),
        .alias_hit(alias_hit), .alias_en(alias_en), .win_start(win_start)
    );

    typedef struct {
        longint xlat;
        bit     hit;
        bit     en;
        longint start;
        longint rd;
        bit     serr;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;

    // Reference model state
    longint m_ctrl;
    bit     m_en;
    longint m_start;

    function automatic int size_lg(input int s);
        if (s == 256) return 8;
        if (s == 512) return 9;
        if (s == 1024) return 10;
        if (s == 2048) return 11;
        return -1;
    endfunction

    function automatic void model_write(input longint d);
        int lg, rows, bank, pexp;
        lg   = size_lg(int'(size_mib));
        rows = int'((d >> 4) & 15) + 1;
        bank = int'((d >> 2) & 1) + 2;
        pexp = int'((d >> 8) & 15) + 3;
        m_ctrl = d;
        if (lg >= 0 && rows == lg + 3) begin
            m_en = 1'b0;
        end else if (lg >= 8 && lg <= 10) begin
            m_en = 1'b1;
            m_start = (longint'(BASE) + (64'd1 << (lg + 3 + bank + pexp))) & AMASK;
        end
    endfunction

    task automatic push_exp(input string tag);
        exp_t e;
        longint a, s;
        a = longint'(req_addr);
        s = m_start;
        e.hit   = m_en && a >= s && a < s + 4096;
        e.xlat  = e.hit ? (longint'(BASE) + (a - s)) : a;
        e.en    = m_en;
        e.start = m_start;
        e.rd    = (reg_addr == 12'd0) ? m_ctrl : 0;
        e.serr  = (size_lg(int'(size_mib)) < 0);
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    task automatic cmp(input string tag, input string fld, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
        end
    endtask

    // Monitor: compare outputs with the oldest expected item.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp(e.tag, "xlat_addr", longint'(xlat_addr), e.xlat);
            cmp(e.tag, "alias_hit", longint'(alias_hit), longint'(e.hit));
            cmp(e.tag, "alias_en", longint'(alias_en), longint'(e.en));
            cmp(e.tag, "win_start", longint'(win_start), e.start);
            cmp(e.tag, "reg_rdata", longint'(reg_rdata), e.rd);
            cmp(e.tag, "size_err", longint'(size_err), longint'(e.serr));
        end
    end

    task automatic do_reset(input int s);
        @(posedge clk); #1;
        rst_n = 1'b0;
        size_mib = 12'(s);
        reg_wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        m_ctrl = 0;
        m_en = 1'b0;
        m_start = longint'(BASE) + 1048576;
    endtask

    task automatic check_req(input longint a, input logic [11:0] off, input string tag);
        @(posedge clk); #1;
        req_addr = AW'(a);
        reg_addr = off;
        push_exp(tag);
    endtask

    // Write, checking the old window in the write cycle and the new one after.
    task automatic write_reg(input logic [11:0] off, input logic [31:0] d, input string tag);
        @(posedge clk); #1;
        reg_wr_en = 1'b1;
        reg_addr  = off;
        reg_wdata = d;
        push_exp({tag, " R10 old window during write"});
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
        if (off == 12'd0) model_write(longint'(d));
        push_exp({tag, " R10 new window after write"});
    endtask

    initial begin
        do_reset(256);
        // R1: reset state, probe the reset-time window location
        check_req(longint'(BASE) + 1048576 + 16, 12'd0, "R1 reset");
        // R5: rows 16, bank 3, page 2^13 -> start = base + 2^27
        write_reg(12'd0, 32'h0000_0AF4, "R5 enable 256");
        check_req(64'h0_4800_0000, 12'd0, "R8 hit at start");
        check_req(64'h0_4800_0FFC, 12'd0, "R8 hit at last word");
        check_req(64'h0_47FF_FFFC, 12'd0, "R9 below window");
        check_req(64'h0_4800_1000, 12'd0, "R9 past window");
        // R2: readback and a write to a different offset
        check_req(64'h0_4800_0010, 12'd0, "R2 readback");
        write_reg(12'd4, 32'h0000_0123, "R2 other offset");
        check_req(64'h0_4800_0010, 12'd4, "R2 other offset reads zero");
        check_req(64'h0_4800_0010, 12'd0, "R2 register kept");
        // R4: rows 11 matches 256 MiB -> window off, start kept
        write_reg(12'd0, 32'h0000_00A0, "R4 disable 256");
        check_req(64'h0_4800_0010, 12'd0, "R4 window off");
        // R3: rows 5, bank 2, page 8 -> start = base + 2^16
        write_reg(12'd0, 32'h0000_0040, "R3 small geometry");
        check_req(64'h0_4001_0008, 12'd0, "R3 hit");
        // R3: bank 3, page 2^6 -> start = base + 2^20
        write_reg(12'd0, 32'h0000_0334, "R3 bank and page");
        check_req(64'h0_4010_0004, 12'd0, "R3 hit at 1 MiB");

        do_reset(512);
        write_reg(12'd0, 32'h0000_0AF4, "R5 enable 512");
        check_req(64'h0_5000_0020, 12'd0, "R8 hit 512");
        write_reg(12'd0, 32'h0000_00B0, "R4 disable 512");
        check_req(64'h0_5000_0020, 12'd0, "R4 off 512");

        do_reset(1024);
        write_reg(12'd0, 32'h0000_05F0, "R5 enable 1024");
        check_req(64'h0_4080_0FF0, 12'd0, "R8 hit 1024");
        check_req(64'h0_4080_1000, 12'd0, "R9 past 1024");
        write_reg(12'd0, 32'h0000_00C0, "R4 disable 1024");

        do_reset(2048);
        write_reg(12'd0, 32'h0000_0AF4, "R6 mismatch 2048 unchanged");
        check_req(64'h0_4010_0000, 12'd0, "R6 no window");
        write_reg(12'd0, 32'h0000_00D0, "R4 match 2048");
        check_req(64'h0_4010_0000, 12'd0, "R4 2048 off");

        do_reset(768);
        write_reg(12'd0, 32'h0000_0AF4, "R7 bad size");
        check_req(64'h0_4800_0000, 12'd0, "R7 no window");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule